// File: doc/BRIEF.md
# USB Device Interrupt Register Bank

This block gathers the interrupt sources of a USB device core into one place and turns them into a single interrupt line. Six bus events are held in a status register: suspend, start of frame, end of bus reset, wakeup, end of resume and upstream resume. Suspend and wakeup are derived inside the block from a bus-idle level. The other four arrive as one-cycle pulses from the framing logic. Each of the endpoints contributes one summary bit. That bit mirrors the endpoint's own pending input and is never latched here.

Software uses a 32-bit write port and a separate combinational read port. The status register and the enable register are both read-only. Each one is changed only through its own write-one-to-set and write-one-to-clear aliases. The interrupt line is high whenever any status bit and its matching enable bit are both 1.

Top module: `usbd_irq_regs`

## Requirements
- R1: After reset the status register, the enable register and `irq` are all 0.
- R2: A pulse on `sof_pulse`, `rst_done_pulse`, `resume_done_pulse` or `remote_wake_pulse` sets status bit 2, 3, 5 or 6 respectively at the next clock edge.
- R3: Writing to word address 1 clears the status bits written as 1. Writing to word address 2 sets status bits written as 1, but only bits 0 and 2 to 6. Status is read at address 0.
- R4: Enable is read at address 3, cleared by writing ones to address 4 and set by writing ones to address 5. Only bits 0, 2 to 6 and 12 to 12+NUM_EP-1 can become 1.
- R5: Status bit 12+n always equals `ep_pend[n]`. Neither status alias can change it.
- R6: `irq` is the OR over all bits of (status AND enable). It follows `ep_pend` without waiting for a clock edge.
- R7: When a hardware event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R8: Zero bits in a write have no effect. Writes to addresses 0, 3, 6 and 7 change nothing.
- R9: Status bit 0 (suspend) sets after IDLE_CYCLES consecutive cycles with `line_idle` high. It sets once per idle stretch, and any active cycle restarts the count.
- R10: Status bit 4 (wakeup) sets on every cycle in which `line_idle` falls, whether or not suspend was reached.
- R11: Reading addresses 1, 2, 4, 5, 6 and 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data, one bit per flag |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data (combinational) |
| line_idle | input | 1 | Bus-idle level from the line monitor |
| sof_pulse | input | 1 | Start-of-frame event |
| rst_done_pulse | input | 1 | End-of-bus-reset event |
| resume_done_pulse | input | 1 | End-of-resume event |
| remote_wake_pulse | input | 1 | Upstream-resume-sent event |
| ep_pend | input | NUM_EP | Per-endpoint pending summary |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are one-cycle pulses and that `wr_en` is low whenever no write is intended. Under these assumptions, a set or clear seen in one cycle shows up in the register at the next edge. The bench drives every input just after a rising edge and holds it for exactly one cycle. It raises `line_idle` only in the suspend and wakeup tests and keeps it low everywhere else. This stops those two flags from appearing in the other expected values.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;

  localparam int REG_W     = 32;
  localparam int BIT_SUSP  = 0;
  localparam int BIT_SOF   = 2;
  localparam int BIT_RST   = 3;
  localparam int BIT_WAKE  = 4;
  localparam int BIT_RSMD  = 5;
  localparam int BIT_UPRSM = 6;
  localparam int EP_BASE   = 12;

  typedef enum logic [2:0] {
    A_STAT     = 3'd0,
    A_STAT_CLR = 3'd1,
    A_STAT_SET = 3'd2,
    A_EN       = 3'd3,
    A_EN_CLR   = 3'd4,
    A_EN_SET   = 3'd5
  } reg_addr_e;

  // Bits that hold latched bus events.
  function automatic logic [REG_W-1:0] global_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_SUSP]  = 1'b1;
    m[BIT_SOF]   = 1'b1;
    m[BIT_RST]   = 1'b1;
    m[BIT_WAKE]  = 1'b1;
    m[BIT_RSMD]  = 1'b1;
    m[BIT_UPRSM] = 1'b1;
    return m;
  endfunction

  // Endpoint summary field for n endpoints.
  function automatic logic [REG_W-1:0] ep_field_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[EP_BASE+i] = 1'b1;
    return m;
  endfunction

  // Place the six event strobes at their status positions.
  function automatic logic [REG_W-1:0] pack_events(
    input logic susp, input logic sof, input logic rst,
    input logic wake, input logic rsmd, input logic uprsm);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_SUSP]  = susp;
    v[BIT_SOF]   = sof;
    v[BIT_RST]   = rst;
    v[BIT_WAKE]  = wake;
    v[BIT_RSMD]  = rsmd;
    v[BIT_UPRSM] = uprsm;
    return v;
  endfunction

  // Next value of a flag register: a hardware set beats a software clear.
  function automatic logic [REG_W-1:0] flag_next(
    input logic [REG_W-1:0] cur, input logic [REG_W-1:0] set_b,
    input logic [REG_W-1:0] clr_b, input logic [REG_W-1:0] hw_b,
    input logic [REG_W-1:0] mask);
    return ((cur & ~clr_b) | set_b | hw_b) & mask;
  endfunction

endpackage

// File: rtl/usbd_idle_watch.sv
module usbd_idle_watch #(
  parameter int IDLE_CYCLES = 144000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_idle,
  output logic susp_evt,
  output logic wake_evt
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);
  localparam logic [CW-1:0] FULL = CW'(IDLE_CYCLES);

  logic [CW-1:0] run_q;
  logic          idle_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= '0;
      idle_d_q <= 1'b0;
    end else begin
      idle_d_q <= line_idle;
      if (!line_idle)
        run_q <= '0;
      else if (run_q != FULL)
        run_q <= run_q + CW'(1);
    end
  end

  // Fires once, on the cycle the run reaches its limit.
  assign susp_evt = line_idle && (run_q == LAST);
  // Any end of an idle stretch counts as bus activity.
  assign wake_evt = !line_idle && idle_d_q;

endmodule

// File: rtl/usbd_wr_decode.sv
module usbd_wr_decode
  import usbd_irq_pkg::*;
(
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] stat_set,
  output logic [REG_W-1:0] stat_clr,
  output logic [REG_W-1:0] en_set,
  output logic [REG_W-1:0] en_clr
);
  always_comb begin
    stat_set = '0;
    stat_clr = '0;
    en_set   = '0;
    en_clr   = '0;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_STAT_CLR: stat_clr = wr_data;
        A_STAT_SET: stat_set = wr_data;
        A_EN_CLR:   en_clr   = wr_data;
        A_EN_SET:   en_set   = wr_data;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/usbd_flag_reg.sv
module usbd_flag_reg
  import usbd_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_b,
  input  logic [REG_W-1:0] clr_b,
  input  logic [REG_W-1:0] hw_b,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= flag_next(q, set_b, clr_b, hw_b, MASK);
  end
endmodule

// File: rtl/usbd_irq_regs.sv
module usbd_irq_regs
  import usbd_irq_pkg::*;
#(
  parameter int NUM_EP      = 8,
  parameter int IDLE_CYCLES = 144000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic              line_idle,
  input  logic              sof_pulse,
  input  logic              rst_done_pulse,
  input  logic              resume_done_pulse,
  input  logic              remote_wake_pulse,
  input  logic [NUM_EP-1:0] ep_pend,
  output logic              irq
);
  localparam logic [REG_W-1:0] GLB_MASK = global_mask();
  localparam logic [REG_W-1:0] EP_MASK  = ep_field_mask(NUM_EP);
  localparam logic [REG_W-1:0] EN_MASK  = GLB_MASK | EP_MASK;

  logic             susp_evt, wake_evt;
  logic [REG_W-1:0] stat_set, stat_clr, en_set, en_clr;
  logic [REG_W-1:0] hw_set;
  logic [REG_W-1:0] stat_q, en_q;
  logic [REG_W-1:0] ep_field, status_view;

  usbd_idle_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .line_idle(line_idle),
    .susp_evt(susp_evt), .wake_evt(wake_evt)
  );

  usbd_wr_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_set(stat_set), .stat_clr(stat_clr),
    .en_set(en_set), .en_clr(en_clr)
  );

  assign hw_set = pack_events(susp_evt, sof_pulse, rst_done_pulse,
                              wake_evt, resume_done_pulse, remote_wake_pulse);

  usbd_flag_reg #(.MASK(GLB_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_b(stat_set), .clr_b(stat_clr),
    .hw_b(hw_set), .q(stat_q)
  );

  usbd_flag_reg #(.MASK(EN_MASK)) u_en (
    .clk(clk), .rst_n(rst_n), .set_b(en_set), .clr_b(en_clr),
    .hw_b('0), .q(en_q)
  );

  // Endpoint summaries pass straight through; they are never stored.
  always_comb begin
    ep_field = '0;
    ep_field[EP_BASE +: NUM_EP] = ep_pend;
  end

  assign status_view = stat_q | ep_field;
  assign irq         = |(status_view & en_q);

  always_comb begin
    case (reg_addr_e'(rd_addr))
      A_STAT:  rd_data = status_view;
      A_EN:    rd_data = en_q;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/usbd_irq_regs_chk.sv
module usbd_irq_regs_chk #(
  parameter int NUM_EP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic              sof_pulse,
  input logic              susp_evt,
  input logic              wake_evt,
  input logic [31:0]       stat_q,
  input logic [31:0]       en_q,
  input logic [31:0]       status_view,
  input logic [NUM_EP-1:0] ep_pend
);
  // R7: a start of frame survives a same-cycle clear
  assert_hw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> stat_q[2]);

  // R3: a clear without a competing event takes effect
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && wr_data[2] && !sof_pulse) |=> !stat_q[2]);

  // R8: an all-zero write leaves enable untouched
  assert_zero_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 32'd0) |=> $stable(en_q));

  // R4: enable only moves through its own aliases
  assert_en_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5)) |=> $stable(en_q));

  // R9: the suspend strobe lands in status bit 0
  assert_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_evt |=> status_view[0]);

  // R10: the wakeup strobe lands in status bit 4
  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> status_view[4]);

  // R5: no endpoint summary is ever held in the latched status
  assert_ep_unlatched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ep_pend == '0 |-> status_view[31:12] == 20'd0);

endmodule

bind usbd_irq_regs usbd_irq_regs_chk #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/tb_usbd_irq_regs.sv
`timescale 1ns/1ps
module tb_usbd_irq_regs;
  localparam int NEP  = 8;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [31:0] rd_data;
  logic line_idle = 1'b0;
  logic sof_pulse = 1'b0, rst_done_pulse = 1'b0;
  logic resume_done_pulse = 1'b0, remote_wake_pulse = 1'b0;
  logic [NEP-1:0] ep_pend = '0;
  logic irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usbd_irq_regs #(.NUM_EP(NEP), .IDLE_CYCLES(IDLE)) dut (.*);

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] d;
    logic [7:0]  ep;
    logic [31:0] st;
    logic [31:0] en;
    logic        irq;
  } vec_t;

  // write address, write data, ep_pend, expected status, enable, irq
  localparam vec_t VECS [11] = '{
    '{3'd2, 32'hFFFF_FFFF, 8'h00, 32'h0000_007D, 32'h0000_0000, 1'b0},
    '{3'd5, 32'h0000_0004, 8'h00, 32'h0000_007D, 32'h0000_0004, 1'b1},
    '{3'd1, 32'h0000_0004, 8'h00, 32'h0000_0079, 32'h0000_0004, 1'b0},
    '{3'd5, 32'hFFFF_FFFF, 8'h05, 32'h0000_5079, 32'h000F_F07D, 1'b1},
    '{3'd1, 32'hFFFF_FFFF, 8'h05, 32'h0000_5000, 32'h000F_F07D, 1'b1},
    '{3'd4, 32'h0000_5000, 8'h05, 32'h0000_5000, 32'h000F_A07D, 1'b0},
    '{3'd5, 32'h0000_0000, 8'h05, 32'h0000_5000, 32'h000F_A07D, 1'b0},
    '{3'd0, 32'hFFFF_FFFF, 8'h80, 32'h0008_0000, 32'h000F_A07D, 1'b1},
    '{3'd4, 32'hFFFF_FFFF, 8'h80, 32'h0008_0000, 32'h0000_0000, 1'b0},
    '{3'd3, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{3'd6, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    rd(3'd0, v); chk("R1 status", v, 32'h0);
    rd(3'd3, v); chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R3 R4 R5 R6 R8: table of alias writes
    for (int i = 0; i < 11; i++) begin
      ep_pend = VECS[i].ep;
      wr(VECS[i].a, VECS[i].d);
      rd(3'd0, v); chk($sformatf("R3/R5/R8 status vec%0d", i), v, VECS[i].st);
      rd(3'd3, v); chk($sformatf("R4/R8 enable vec%0d", i), v, VECS[i].en);
      chk($sformatf("R6 irq vec%0d", i), {31'd0, irq}, {31'd0, VECS[i].irq});
    end

    // R11: write-only aliases read as zero
    wr(3'd2, 32'h0000_0008);
    rd(3'd1, v); chk("R11 read addr1", v, 32'h0);
    rd(3'd2, v); chk("R11 read addr2", v, 32'h0);
    rd(3'd5, v); chk("R11 read addr5", v, 32'h0);

    // R2: each event pulse lands on its own bit
    wr(3'd1, 32'hFFFF_FFFF);
    sof_pulse = 1'b1; tick(); sof_pulse = 1'b0;
    rd(3'd0, v); chk("R2 sof bit2", v, 32'h0000_0004);
    wr(3'd1, 32'hFFFF_FFFF);
    rst_done_pulse = 1'b1; tick(); rst_done_pulse = 1'b0;
    rd(3'd0, v); chk("R2 reset-done bit3", v, 32'h0000_0008);
    wr(3'd1, 32'hFFFF_FFFF);
    resume_done_pulse = 1'b1; tick(); resume_done_pulse = 1'b0;
    rd(3'd0, v); chk("R2 resume-done bit5", v, 32'h0000_0020);
    wr(3'd1, 32'hFFFF_FFFF);
    remote_wake_pulse = 1'b1; tick(); remote_wake_pulse = 1'b0;
    rd(3'd0, v); chk("R2 upstream-resume bit6", v, 32'h0000_0040);

    // R7: event beats a same-cycle clear
    wr(3'd1, 32'hFFFF_FFFF);
    sof_pulse = 1'b1; wr(3'd1, 32'h0000_0004); sof_pulse = 1'b0;
    rd(3'd0, v); chk("R7 sof vs clear", v, 32'h0000_0004);
    wr(3'd1, 32'h0000_0004);
    rd(3'd0, v); chk("R3 clear alone", v, 32'h0);

    // R6: irq tracks an enabled endpoint without a clock edge
    wr(3'd5, 32'h0000_2000);
    ep_pend = 8'h02; #0.5;
    chk("R6 irq ep1 high", {31'd0, irq}, 32'd1);
    ep_pend = 8'h00; #0.5;
    chk("R6 irq ep1 low", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'hFFFF_FFFF);

    // R9: suspend after IDLE idle cycles, once per stretch
    line_idle = 1'b1;
    repeat (IDLE - 1) tick();
    rd(3'd0, v); chk("R9 before limit", v, 32'h0);
    tick();
    rd(3'd0, v); chk("R9 at limit", v, 32'h0000_0001);
    wr(3'd1, 32'h0000_0001);
    repeat (20) tick();
    rd(3'd0, v); chk("R9 single per stretch", v, 32'h0);

    // R10: wakeup after suspend
    line_idle = 1'b0; tick();
    rd(3'd0, v); chk("R10 wake after suspend", v, 32'h0000_0010);
    wr(3'd1, 32'hFFFF_FFFF);

    // R9/R10: activity restarts the count; wake without suspend
    line_idle = 1'b1; repeat (IDLE - 1) tick();
    line_idle = 1'b0; tick();
    rd(3'd0, v); chk("R10 wake without suspend", v, 32'h0000_0010);
    line_idle = 1'b1; repeat (IDLE - 1) tick();
    rd(3'd0, v); chk("R9 count restarted", v, 32'h0000_0010);
    tick();
    rd(3'd0, v); chk("R9 full run after restart", v, 32'h0000_0011);
    line_idle = 1'b0; tick();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule